// File: doc/BRIEF.md
# PIPE Receiver Detect Sequencer

This per-lane controller runs the far-end receiver detection handshake of a PCIe PIPE-style PHY. The MAC raises a single request line while link training sits in the Detect state. When the lane is in power state P1, the request launches a detect command toward the transmitter driver, and the transmitter output stays in electrical idle throughout. An abstracted analog comparator later answers with a present/absent verdict. The block then reports completion with a one-cycle PHY status strobe and a coded 3-bit receive status.

A request that arrives in any power state other than P1 is not a detect request for this block and produces no activity. Each sequence needs a fresh request: the line must drop and rise again. A built-in timeout closes the sequence with an "absent" verdict if the comparator never answers.

Top module: `rxdet_seq`

## Requirements
- R1: After reset, `phy_status_o`, `det_cmd_o` and `rx_status_o` are 0. While `pwr_state_i` is not P1 and no sequence runs, `tx_elec_idle_o` is 0.
- R2: A sequence starts on the clock edge that samples `det_req_i` high with `pwr_state_i` equal to P1 (code 2'd2), provided the request was sampled low on an earlier edge while idle. `det_cmd_o` is 1 from that edge until the edge that closes the sequence.
- R3: `tx_elec_idle_o` is 1 whenever `pwr_state_i` is P1 or a sequence is running.
- R4: If the edge that samples `cmp_valid_i` high during a sequence also samples `cmp_present_i` high, then from that edge `phy_status_o` is 1 for exactly one cycle with `rx_status_o` = 3'b011, and `det_cmd_o` falls.
- R5: If the edge that samples `cmp_valid_i` high during a sequence samples `cmp_present_i` low, then `phy_status_o` pulses for one cycle with `rx_status_o` = 3'b000.
- R6: If `cmp_valid_i` is not sampled high during the first TIMEOUT_CYCLES edges after the start edge, the sequence closes on the TIMEOUT_CYCLES-th edge after the start edge with a one-cycle `phy_status_o` pulse and `rx_status_o` = 3'b000.
- R7: A request sampled high outside P1 starts nothing and gives no pulse. It also cannot start a sequence later if it stays high while the lane moves into P1.
- R8: A request held high after completion, or dropped and raised again while a sequence runs, starts no further sequence.
- R9: `cmp_valid_i` sampled high while no sequence runs has no effect: no pulse follows.
- R10: `rx_status_o` is 3'b000 in every cycle in which `phy_status_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Active-low synchronous reset |
| det_req_i | input | 1 | Detect/loopback request from the MAC |
| pwr_state_i | input | PWR_W | Power state (P0=0, P0s=1, P1=2, P2=3) |
| cmp_valid_i | input | 1 | Comparator verdict valid |
| cmp_present_i | input | 1 | Comparator verdict: far-end receiver present |
| det_cmd_o | output | 1 | Detect command to the transmitter driver, high during a sequence |
| tx_elec_idle_o | output | 1 | Hold transmitter in electrical idle |
| phy_status_o | output | 1 | One-cycle completion strobe |
| rx_status_o | output | 3 | Receive status code, valid with the strobe |

## Verification
The bench builds the block with TIMEOUT_CYCLES set to 16 instead of the default 1024. This puts both the timeout closure and the last-chance verdict (latency exactly 16) within a few dozen cycles. It drives verdict latencies of 1, mid-range, 16 and none, so the edge where a late verdict still wins and the edge where the timeout takes over can both be reached and timed exactly.

// File: rtl/rxdet_seq.sv
module rxdet_seq #(
  parameter int               TIMEOUT_CYCLES = 1024,
  parameter int               PWR_W          = 2,
  parameter logic [PWR_W-1:0] P1_CODE        = PWR_W'(2),
  parameter logic [2:0]       CODE_PRESENT   = 3'b011
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det_req_i,
  input  logic [PWR_W-1:0] pwr_state_i,
  input  logic             cmp_valid_i,
  input  logic             cmp_present_i,
  output logic             det_cmd_o,
  output logic             tx_elec_idle_o,
  output logic             phy_status_o,
  output logic [2:0]       rx_status_o
);
  localparam int             CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  logic             busy;
  logic             armed;
  logic [CNT_W-1:0] cnt;

  wire in_p1  = (pwr_state_i == P1_CODE);
  wire idle   = !busy && !phy_status_o;
  wire start  = idle && armed && det_req_i && in_p1;
  wire finish = busy && (cmp_valid_i || cnt == LAST);

  assign det_cmd_o      = busy;
  assign tx_elec_idle_o = in_p1 || busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      armed        <= 1'b0;
      cnt          <= '0;
      phy_status_o <= 1'b0;
      rx_status_o  <= 3'b000;
    end else begin
      busy         <= start || (busy && !finish);
      armed        <= idle && !det_req_i;
      cnt          <= (busy && !finish) ? cnt + 1'b1 : '0;
      phy_status_o <= finish;
      rx_status_o  <= (finish && cmp_valid_i && cmp_present_i) ? CODE_PRESENT : 3'b000;
    end
  end
endmodule

// File: rtl/rxdet_seq_chk.sv
module rxdet_seq_chk #(
  parameter int               TIMEOUT_CYCLES = 1024,
  parameter int               PWR_W          = 2,
  parameter logic [PWR_W-1:0] P1_CODE        = PWR_W'(2)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             det_req_i,
  input logic [PWR_W-1:0] pwr_state_i,
  input logic             det_cmd_o,
  input logic             tx_elec_idle_o,
  input logic             phy_status_o,
  input logic [2:0]       rx_status_o
);
  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (!rst_n)         run_len <= 0;
    else if (det_cmd_o) run_len <= run_len + 1;
    else                run_len <= 0;
  end

  p_start_in_p1_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(det_cmd_o) |-> $past(det_req_i && pwr_state_i == P1_CODE));

  p_idle_during_detect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    det_cmd_o |-> tx_elec_idle_o);

  p_single_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    phy_status_o |=> !phy_status_o);

  p_pulse_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(det_cmd_o) |-> phy_status_o);

  p_pulse_after_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_status_o) |-> $past(det_cmd_o));

  p_timeout_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= TIMEOUT_CYCLES);

  p_status_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !phy_status_o |-> rx_status_o == 3'b000);
endmodule

bind rxdet_seq rxdet_seq_chk #(
  .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .PWR_W(PWR_W), .P1_CODE(P1_CODE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .det_req_i(det_req_i), .pwr_state_i(pwr_state_i),
  .det_cmd_o(det_cmd_o), .tx_elec_idle_o(tx_elec_idle_o),
  .phy_status_o(phy_status_o), .rx_status_o(rx_status_o)
);

// File: tb/rxdet_seq_tb_top.sv
module rxdet_seq_tb_top;
  localparam int T = 16;
  localparam logic [1:0] P0 = 2'd0, P1 = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic det_req = 1'b0, cmp_valid = 1'b0, cmp_present = 1'b0;
  logic [1:0] pwr = P0;
  logic det_cmd, tx_idle, phy_status;
  logic [2:0] rx_status;

  int checks = 0, failures = 0, pulses = 0;
  bit done = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  rxdet_seq #(.TIMEOUT_CYCLES(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .det_req_i(det_req), .pwr_state_i(pwr),
    .cmp_valid_i(cmp_valid), .cmp_present_i(cmp_present),
    .det_cmd_o(det_cmd), .tx_elec_idle_o(tx_idle),
    .phy_status_o(phy_status), .rx_status_o(rx_status)
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per strobe, checks quiet status otherwise
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (phy_status) begin
        pulses++;
        if (exp_q.size() == 0) check("R8 R9 unexpected strobe", 4'd1, 4'd0);
        else check(tag_q.pop_front(), {1'b0, rx_status}, {1'b0, exp_q.pop_front()});
      end else begin
        check("R10 status quiet", {1'b0, rx_status}, 4'd0);
      end
    end
  end

  // driver: lat=0 means the comparator never answers
  task automatic run_seq(input string tag, input int lat, input bit present, input bit toggle);
    int e;
    e = (lat >= 1 && lat <= T) ? lat + 1 : T + 1;
    exp_q.push_back((lat >= 1 && lat <= T && present) ? 3'b011 : 3'b000);
    tag_q.push_back(tag);
    @(negedge clk);
    det_req = 1'b1;
    for (int k = 1; k <= e; k++) begin
      @(negedge clk);
      if (k == 1) begin
        check({"R2 cmd raised ", tag}, {3'b0, det_cmd}, 4'd1);
        check({"R3 idle in run ", tag}, {3'b0, tx_idle}, 4'd1);
      end
      if (toggle && k == 2) det_req = 1'b0;
      if (toggle && k == 3) det_req = 1'b1;
      if (k == e) begin
        check({"R6 strobe timing ", tag}, {3'b0, phy_status}, 4'd1);
        check({"R4 cmd dropped ", tag}, {3'b0, det_cmd}, 4'd0);
      end else begin
        check({"R6 no early strobe ", tag}, {3'b0, phy_status}, 4'd0);
      end
      cmp_valid = (k == lat);
      cmp_present = present;
    end
    cmp_valid = 1'b0;
  endtask

  task automatic quiet(input string tag, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(tag, {2'b0, det_cmd, phy_status}, 4'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset outputs", {det_cmd, tx_idle, phy_status, 1'b0}, 4'd0);
    check("R1 reset status", {1'b0, rx_status}, 4'd0);

    pwr = P1;
    @(negedge clk);
    check("R3 idle in P1", {3'b0, tx_idle}, 4'd1);

    run_seq("R4 present lat3", 3, 1'b1, 1'b0);
    det_req = 1'b0; quiet("R4 after", 2);
    run_seq("R5 absent lat5", 5, 1'b0, 1'b0);
    det_req = 1'b0; quiet("R5 after", 2);
    run_seq("R4 present lat1", 1, 1'b1, 1'b0);
    det_req = 1'b0; quiet("R4 after lat1", 2);
    run_seq("R6 present at limit", T, 1'b1, 1'b0);
    det_req = 1'b0; quiet("R6 after limit", 2);
    run_seq("R6 timeout", 0, 1'b1, 1'b0);
    // R8: request stays high after completion
    quiet("R8 held high", 10);
    det_req = 1'b0; quiet("R8 released", 2);
    // R8: toggles during a running sequence
    run_seq("R8 toggle in run", 6, 1'b1, 1'b1);
    quiet("R8 no restart after toggle", 6);
    det_req = 1'b0; quiet("R8 released", 2);

    // R7: request outside P1, then move into P1 with it held
    pwr = P0;
    @(negedge clk);
    det_req = 1'b1;
    quiet("R7 request in P0", 8);
    pwr = P1;
    quiet("R7 held into P1", 8);
    det_req = 1'b0; quiet("R7 released", 2);

    // R9: comparator verdict while idle
    cmp_valid = 1'b1; cmp_present = 1'b1;
    @(negedge clk);
    cmp_valid = 1'b0;
    quiet("R9 stray verdict", 5);

    run_seq("R2 fresh after stray", 2, 1'b1, 1'b0);
    det_req = 1'b0; quiet("R2 after", 2);

    check("R4 all strobes seen", exp_q.size() == 0 ? 4'd0 : 4'd1, 4'd0);
    check("R4 strobe count", pulses[3:0], 4'd7);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule